// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block sits next to a small processor core and decides which of its interrupt sources is serviced next. Every request input is captured into a pending bit that stays set until the controller acknowledges that source. A per-source enable register is written through a masked write port. A single global enable flag gates all sources at once. When the core reports that an instruction has finished, the controller may fire a one-cycle take strobe. In the same cycle it presents the winning source number and that source's vector address. The core then pushes its return address and jumps to the vector itself.

Source number doubles as priority: the lowest-numbered enabled pending source wins. Its vector is the source number times two, because each vector slot is two words wide. Taking an interrupt clears the global flag, so a running service routine is not disturbed. Requests that arrive meanwhile stay pending. The flag comes back on when the core signals a return from interrupt. Software may also set it early inside a routine to allow nesting. No other status is saved or restored by this block. The take strobe is a single-cycle pulse at an instruction boundary and has no back-pressure: the core must accept it in the cycle it appears. All pins are plain control pins.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset, every pending bit, every local enable and the global flag are 0, and `take_o` is 0.
- R2: A request high for a single cycle is remembered as pending and is serviced at a later boundary, however many cycles later.
- R3: `take_o` is high in a cycle only if `instr_done_i` is high, the global flag is set, and at least one source is both pending and locally enabled. In every other cycle `take_o` is 0.
- R4: When `take_o` is high, `src_o` is the lowest-numbered enabled pending source and `vector_o` equals 2 × `src_o`. For example, source 0 gives 0x00, source 1 gives 0x02, and source 20 gives 0x28.
- R5: In the cycle after `take_o` is high, `gie_o` reads 0.
- R6: The acknowledged source's pending bit is cleared on the clock edge that ends the take cycle. If that same source's request input is high in the take cycle, the bit is set again.
- R7: The global flag updates by priority: a take clears it; otherwise `reti_i` sets it; otherwise `gie_set_i` sets it; otherwise `gie_clr_i` clears it.
- R8: A write with `en_we_i` high replaces only the enable bits selected by `en_wmask_i` with `en_wdata_i`. A pending source whose enable is 0 is never taken, but it stays pending and is taken once it is enabled.
- R9: While the global flag is 0, requests keep accumulating as pending and none is taken. They are taken after the flag is set again.
- R10: Setting the global flag with `gie_set_i` inside a service routine allows another take at the next boundary (nesting).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| req_i | input | NUM_SRC | Interrupt request per source, bit n is source n |
| en_we_i | input | 1 | Enable register write strobe |
| en_wmask_i | input | NUM_SRC | Bits of the enable register affected by the write |
| en_wdata_i | input | NUM_SRC | New enable values for the masked bits |
| gie_set_i | input | 1 | Software sets the global flag |
| gie_clr_i | input | 1 | Software clears the global flag |
| reti_i | input | 1 | Core executes a return from interrupt |
| instr_done_i | input | 1 | Current instruction completes this cycle |
| take_o | output | 1 | Interrupt taken this cycle (acknowledge) |
| vector_o | output | VEC_W | Vector address of the winning source |
| src_o | output | IDX_W | Number of the winning source |
| gie_o | output | 1 | Current global enable flag |

## Verification
A stuck or lost pending bit shows up as a missing or extra take, or a wrong vector, at the next instruction boundary where the global flag is set. A global flag that fails to clear on a take shows on `gie_o` in the very next cycle. An enable register write that spills outside its mask shows as a take from a source that should have been blocked, or the absence of one that should have won. The bench compares every output against a behavioural model on every cycle, so such a divergence is reported within one cycle of its first visible effect.

// File: rtl/irq_pkg.sv
package irq_pkg;

  // Global flag update request, resolved in priority order
  typedef enum logic [1:0] {
    GIE_KEEP  = 2'd0,
    GIE_CLEAR = 2'd1,
    GIE_SET   = 2'd2
  } gie_op_e;

  function automatic gie_op_e gie_resolve(input logic take, input logic reti,
                                          input logic sw_set, input logic sw_clr);
    gie_op_e op;
    if (take)        op = GIE_CLEAR;
    else if (reti)   op = GIE_SET;
    else if (sw_set) op = GIE_SET;
    else if (sw_clr) op = GIE_CLEAR;
    else             op = GIE_KEEP;
    return op;
  endfunction

endpackage

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
  parameter int NUM_SRC = 21
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] req_i,
  input  logic [NUM_SRC-1:0] ack_onehot_i,
  input  logic               en_we_i,
  input  logic [NUM_SRC-1:0] en_wmask_i,
  input  logic [NUM_SRC-1:0] en_wdata_i,
  output logic [NUM_SRC-1:0] pend_o,
  output logic [NUM_SRC-1:0] en_o
);

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    logic pend_q;
    logic en_q;

    // Ack clears first, a request in the same cycle sets again
    always_ff @(posedge clk_i) begin
      if (!rst_ni) pend_q <= 1'b0;
      else         pend_q <= (pend_q & ~ack_onehot_i[g]) | req_i[g];
    end

    always_ff @(posedge clk_i) begin
      if (!rst_ni)                       en_q <= 1'b0;
      else if (en_we_i && en_wmask_i[g]) en_q <= en_wdata_i[g];
    end

    assign pend_o[g] = pend_q;
    assign en_o[g]   = en_q;
  end

endmodule

// File: rtl/irq_lowest_pick.sv
module irq_lowest_pick #(
  parameter int NUM_SRC = 21,
  localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic [NUM_SRC-1:0] cand_i,
  output logic               any_o,
  output logic [IDX_W-1:0]   idx_o,
  output logic [NUM_SRC-1:0] onehot_o
);

  // Thermometer of "some lower source is a candidate"
  logic [NUM_SRC:0] below;
  assign below[0] = 1'b0;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_chain
    assign below[g+1]  = below[g] | cand_i[g];
    assign onehot_o[g] = cand_i[g] & ~below[g];
  end

  assign any_o = below[NUM_SRC];

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (onehot_o[i]) idx_o = IDX_W'(i);
    end
  end

endmodule

// File: rtl/irq_gie_unit.sv
module irq_gie_unit
  import irq_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic take_i,
  input  logic reti_i,
  input  logic sw_set_i,
  input  logic sw_clr_i,
  output logic gie_o
);

  gie_op_e op;
  logic    gie_q;

  assign op = gie_resolve(take_i, reti_i, sw_set_i, sw_clr_i);

  always_ff @(posedge clk_i) begin
    if (!rst_ni) gie_q <= 1'b0;
    else begin
      case (op)
        GIE_SET:   gie_q <= 1'b1;
        GIE_CLEAR: gie_q <= 1'b0;
        default:   gie_q <= gie_q;
      endcase
    end
  end

  assign gie_o = gie_q;

endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl #(
  parameter int NUM_SRC    = 21,
  parameter int VEC_STRIDE = 2,
  localparam int IDX_W     = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
  localparam int VEC_W     = $clog2((NUM_SRC - 1) * VEC_STRIDE + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] req_i,
  input  logic               en_we_i,
  input  logic [NUM_SRC-1:0] en_wmask_i,
  input  logic [NUM_SRC-1:0] en_wdata_i,
  input  logic               gie_set_i,
  input  logic               gie_clr_i,
  input  logic               reti_i,
  input  logic               instr_done_i,
  output logic               take_o,
  output logic [VEC_W-1:0]   vector_o,
  output logic [IDX_W-1:0]   src_o,
  output logic               gie_o
);

  logic [NUM_SRC-1:0] pend_q;
  logic [NUM_SRC-1:0] en_q;
  logic [NUM_SRC-1:0] cand;
  logic [NUM_SRC-1:0] win_onehot;
  logic [NUM_SRC-1:0] ack_onehot;
  logic               any_cand;
  logic [IDX_W-1:0]   win_idx;
  logic               take;

  irq_pend_bank #(.NUM_SRC(NUM_SRC)) u_bank (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_i        (req_i),
    .ack_onehot_i (ack_onehot),
    .en_we_i      (en_we_i),
    .en_wmask_i   (en_wmask_i),
    .en_wdata_i   (en_wdata_i),
    .pend_o       (pend_q),
    .en_o         (en_q)
  );

  assign cand = pend_q & en_q;

  irq_lowest_pick #(.NUM_SRC(NUM_SRC)) u_pick (
    .cand_i   (cand),
    .any_o    (any_cand),
    .idx_o    (win_idx),
    .onehot_o (win_onehot)
  );

  assign take       = instr_done_i & gie_o & any_cand;
  assign ack_onehot = take ? win_onehot : '0;

  irq_gie_unit u_gie (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .take_i   (take),
    .reti_i   (reti_i),
    .sw_set_i (gie_set_i),
    .sw_clr_i (gie_clr_i),
    .gie_o    (gie_o)
  );

  assign take_o   = take;
  assign src_o    = win_idx;
  assign vector_o = VEC_W'(int'(win_idx) * VEC_STRIDE);

endmodule

// File: rtl/irq_vector_ctrl_chk.sv
module irq_vector_ctrl_chk #(
  parameter int NUM_SRC    = 21,
  parameter int VEC_STRIDE = 2,
  parameter int IDX_W      = 5,
  parameter int VEC_W      = 6
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [NUM_SRC-1:0] req_i,
  input logic               reti_i,
  input logic               instr_done_i,
  input logic               take_o,
  input logic [VEC_W-1:0]   vector_o,
  input logic [IDX_W-1:0]   src_o,
  input logic               gie_o,
  input logic [NUM_SRC-1:0] pend_q
);

  AST_TAKE_AT_BOUNDARY: assert property (@(posedge clk_i) disable iff (!rst_ni) take_o |-> instr_done_i); // R3
  AST_TAKE_NEEDS_GIE: assert property (@(posedge clk_i) disable iff (!rst_ni) take_o |-> gie_o); // R3
  AST_VEC_IN_TABLE: assert property (@(posedge clk_i) disable iff (!rst_ni) take_o |-> ((int'(vector_o) % VEC_STRIDE) == 0 && int'(vector_o) < NUM_SRC * VEC_STRIDE)); // R4
  AST_GIE_DROPS_ON_TAKE: assert property (@(posedge clk_i) disable iff (!rst_ni) take_o |=> !gie_o); // R5
  AST_ACK_RELATCH: assert property (@(posedge clk_i) disable iff (!rst_ni) take_o |=> pend_q[$past(src_o)] == $past(req_i[src_o])); // R6
  AST_RETI_RESTORES: assert property (@(posedge clk_i) disable iff (!rst_ni) (reti_i && !take_o) |=> gie_o); // R7

endmodule

bind irq_vector_ctrl irq_vector_ctrl_chk #(
  .NUM_SRC(NUM_SRC), .VEC_STRIDE(VEC_STRIDE), .IDX_W(IDX_W), .VEC_W(VEC_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .reti_i(reti_i),
  .instr_done_i(instr_done_i), .take_o(take_o), .vector_o(vector_o),
  .src_o(src_o), .gie_o(gie_o), .pend_q(pend_q)
);

// File: tb/tb_irq_vector_ctrl.sv
module tb_irq_vector_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int N  = 21;
  localparam int IW = 5;
  localparam int VW = 6;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [N-1:0]  req, wmask, wdata;
  logic          we, gset, gclr, reti, done;
  logic          take;
  logic [VW-1:0] vec;
  logic [IW-1:0] src;
  logic          gie;

  int n_tests = 0;
  int n_fail  = 0;

  // reference model state
  logic [N-1:0] m_pend, m_en;
  logic         m_gie;
  // outputs seen in the last step
  logic         l_take, l_gie;
  int           l_vec, l_src;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_vector_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .en_we_i(we),
    .en_wmask_i(wmask), .en_wdata_i(wdata), .gie_set_i(gset),
    .gie_clr_i(gclr), .reti_i(reti), .instr_done_i(done),
    .take_o(take), .vector_o(vec), .src_o(src), .gie_o(gie)
  );

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input logic [N-1:0] r, input logic w, input logic [N-1:0] m,
                      input logic [N-1:0] d, input logic s, input logic c,
                      input logic rt, input logic b);
    logic [N-1:0] cand;
    logic         e_take;
    int           e_src;
    @(negedge clk);
    req = r; we = w; wmask = m; wdata = d; gset = s; gclr = c; reti = rt; done = b;
    #1;
    cand  = m_pend & m_en;
    e_src = 0;
    for (int i = N - 1; i >= 0; i--) if (cand[i]) e_src = i;
    e_take = b && m_gie && (cand != '0);
    check(take === e_take, "R3 take", int'(take), int'(e_take));
    check(gie === m_gie, "R7 gie", int'(gie), int'(m_gie));
    if (e_take) begin
      check(int'(src) == e_src, "R4 src", int'(src), e_src);
      check(int'(vec) == 2 * e_src, "R4 vector", int'(vec), 2 * e_src);
    end
    l_take = take; l_gie = gie; l_vec = int'(vec); l_src = int'(src);
    // next model state
    if (e_take) m_pend[e_src] = 1'b0;
    m_pend = m_pend | r;
    if (w) m_en = (m_en & ~m) | (d & m);
    if (e_take)  m_gie = 1'b0;
    else if (rt) m_gie = 1'b1;
    else if (s)  m_gie = 1'b1;
    else if (c)  m_gie = 1'b0;
  endtask

  task automatic idle(input logic b);
    step('0, 1'b0, '0, '0, 1'b0, 1'b0, 1'b0, b);
  endtask

  function automatic logic [N-1:0] bit_n(input int n);
    return N'(1) << n;
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    req = '0; we = 0; wmask = '0; wdata = '0; gset = 0; gclr = 0; reti = 0; done = 1;
    m_pend = '0; m_en = '0; m_gie = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(take === 1'b0, "R1 take after reset", int'(take), 0);
    check(gie === 1'b0, "R1 gie after reset", int'(gie), 0);
    rst_n = 1'b1;

    // R9: enable 0..3, requests 1 and 2 while flag is off
    step(bit_n(1) | bit_n(2), 1'b1, '1, N'(4'hF), 0, 0, 0, 0);
    idle(1'b1);
    check(l_take == 1'b0, "R9 no take while flag off", int'(l_take), 0);
    step('0, 0, '0, '0, 1, 0, 0, 0);
    idle(1'b1);
    check(l_take && l_vec == 2, "R4 lowest wins vector 0x02", l_vec, 2);
    idle(1'b0);
    check(l_gie == 1'b0, "R5 flag cleared after take", int'(l_gie), 0);
    idle(1'b1);
    check(l_take == 1'b0, "R9 source 2 held while in service", int'(l_take), 0);
    step('0, 0, '0, '0, 0, 0, 1, 0);
    idle(1'b0);
    check(l_take == 1'b0, "R3 no take off boundary", int'(l_take), 0);
    idle(1'b1);
    check(l_take && l_vec == 4, "R2 pending kept, vector 0x04", l_vec, 4);

    // R6: request on the acknowledged source in the take cycle
    step('0, 0, '0, '0, 0, 0, 1, 0);
    step(bit_n(3), 0, '0, '0, 0, 0, 0, 0);
    step(bit_n(3), 0, '0, '0, 0, 0, 0, 1);
    check(l_take && l_src == 3, "R6 first take of source 3", l_src, 3);
    step('0, 0, '0, '0, 0, 0, 1, 0);
    idle(1'b1);
    check(l_take && l_src == 3, "R6 relatched source 3", l_src, 3);

    // R8: disabled source stays pending, masked write
    step(bit_n(10), 0, '0, '0, 0, 0, 1, 0);
    idle(1'b1);
    check(l_take == 1'b0, "R8 disabled source not taken", int'(l_take), 0);
    step('0, 1, bit_n(10), '1, 0, 0, 0, 0);
    idle(1'b1);
    check(l_take && l_vec == 20, "R8 taken once enabled", l_vec, 20);

    // R10: nesting after software sets the flag
    step(bit_n(0), 0, '0, '0, 1, 0, 0, 0);
    idle(1'b1);
    check(l_take && l_vec == 0, "R10 nested take vector 0x00", l_vec, 0);

    // R7: take beats a software set in the same cycle
    step(bit_n(1), 0, '0, '0, 0, 0, 1, 0);
    step('0, 0, '0, '0, 1, 0, 0, 1);
    idle(1'b0);
    check(l_gie == 1'b0, "R7 take beats set", int'(l_gie), 0);
    step('0, 0, '0, '0, 1, 1, 0, 0);
    idle(1'b0);
    check(l_gie == 1'b1, "R7 set beats clear", int'(l_gie), 1);
    step('0, 0, '0, '0, 0, 1, 0, 0);
    idle(1'b0);
    check(l_gie == 1'b0, "R7 software clear", int'(l_gie), 0);

    // R4: highest-numbered source
    step(bit_n(N-1), 1, bit_n(N-1), '1, 0, 0, 1, 0);
    idle(1'b1);
    check(l_take && l_vec == 40, "R4 last source vector 0x28", l_vec, 40);

    // random traffic, model compared every cycle
    for (int k = 0; k < 4000; k++) begin
      logic [N-1:0] r;
      r = ($urandom_range(0, 3) == 0) ? bit_n($urandom_range(0, N-1)) : '0;
      if ($urandom_range(0, 15) == 0) r = r | bit_n($urandom_range(0, N-1));
      step(r, ($urandom_range(0, 19) == 0), N'($urandom), N'($urandom),
           ($urandom_range(0, 9) == 0), ($urandom_range(0, 14) == 0),
           ($urandom_range(0, 7) == 0), ($urandom_range(0, 2) != 0));
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule